// File: doc/BRIEF.md
# NMI Entry and Stack Return Sequencer

This block is the part of a small 8-bit CPU core with a 16-bit program counter that moves the program counter through the stack. It runs four multi-cycle sequences over a byte-wide memory bus. The first is the non-maskable interrupt entry. The other three are the stack halves of subroutine call (JSR), subroutine return (RTS) and return from interrupt (RTI). The instruction decoder raises `instr_done` in the last cycle of each instruction it runs itself. In that cycle it presents the address of the next instruction on `pc_in` and the class of that next instruction on `op_kind`. The sequencer then does one of three things: it takes the interrupt, it runs the requested stack sequence, or it stays idle.

The interrupt input is active low and edge sensitive. A falling edge is remembered in a pending latch. The latch is examined only at an instruction boundary, so an instruction that is already under way always runs to its end. The last cycle of a sequence is itself a boundary. When an interrupt is pending there, the entry sequence follows at once and pushes the program counter that the finished sequence has just produced.

The two return conventions differ. A call stores its return address minus one, and a subroutine return adds the one back. An interrupt stores the exact resume address, and its return uses the pulled value unchanged. The stack lives in memory page 0x01 and is addressed by an 8-bit pointer that wraps within that page.

Top module: `nmi_stack_seq`

## Requirements
- R1: After synchronous reset, `busy`, `pc_valid` and `mem_we` are 0, `sp_out` is 0xFF, and `flags_out` and `pc_out` are 0.
- R2: A falling edge on `nmi_n` sets a pending latch. The latch is acted on only at a boundary: `instr_done` while idle, or the last cycle of a sequence. Holding `nmi_n` low does not trigger a second entry. An edge that arrives while a sequence runs stays pending.
- R3: The interrupt entry keeps `busy` high for 7 cycles. It writes `pc_in[15:8]` to 0x0100+SP, then `pc_in[7:0]`, then `flags_in`, and SP drops by one after each write. It then reads 0xFFFA (low) and 0xFFFB (high), and `pc_out` becomes {[0xFFFB],[0xFFFA]}.
- R4: When an interrupt is pending at an `instr_done` boundary, the entry runs and the `op_kind` offered in that cycle is ignored.
- R5: JSR (`op_kind`=1) keeps `busy` high for 6 cycles. It reads the target low byte at `pc_in`+1 and the high byte at `pc_in`+2. It pushes (`pc_in`+2), high byte first, so SP drops by 2, and `pc_out` becomes the target.
- R6: RTS (`op_kind`=2) keeps `busy` high for 6 cycles. It pulls the low byte from 0x0100+SP+1 and then the high byte, with SP incremented before each pull. `pc_out` is the pulled address plus one, and SP rises by 2.
- R7: RTI (`op_kind`=3) keeps `busy` high for 6 cycles. It pulls the status byte into `flags_out`, then the PC low byte, then the PC high byte. `pc_out` is the pulled address unchanged, and SP rises by 3.
- R8: `pc_valid` is a one-cycle pulse in the first cycle after `busy` falls. It does not pulse when a sequence chains straight into an interrupt entry.
- R9: `instr_done` and `op_kind` are ignored while `busy` is high.
- R10: `mem_we` is asserted only during push cycles and only with an address in 0x0100–0x01FF.
- R11: If an interrupt is pending in the last cycle of a JSR, RTS or RTI, the entry begins in the next cycle with no idle cycle in between. It pushes the program counter that the finished sequence produced.
- R12: The stack pointer wraps modulo 256 within page 0x01 on both push and pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_n | input | 1 | Non-maskable interrupt request, falling-edge sensitive |
| instr_done | input | 1 | Last cycle of the current decoder-run instruction |
| op_kind | input | 2 | Next instruction class: 0 none, 1 JSR, 2 RTS, 3 RTI |
| pc_in | input | 16 | Address of the next instruction at the boundary |
| flags_in | input | 8 | Status byte pushed on interrupt entry |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_addr` |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write strobe |
| pc_out | output | 16 | Program counter produced by the last sequence |
| pc_valid | output | 1 | One-cycle pulse when `pc_out` is ready for the fetch |
| busy | output | 1 | A sequence is running |
| flags_out | output | 8 | Status byte restored by RTI |
| sp_out | output | 8 | Stack pointer (low byte of the stack address) |

## Verification
Two functions can meet in one cycle. An interrupt edge can be latched while a return sequence is running, so the pending latch is examined in the same cycle that the return computes its new program counter. The bench provokes this by pulsing `nmi_n` in the middle of an RTS. It judges the result by four things: the total busy length of 13 cycles, the absence of a `pc_valid` pulse between the two sequences, the pushed bytes equal to the pulled address plus one, and the final stack pointer. A second collision, a pending interrupt together with an `op_kind` request at the same boundary, is judged by the stack depth and the cycle count of an entry rather than of the requested sequence.

// File: rtl/nmi_seq_pkg.sv
package nmi_seq_pkg;

    localparam int PC_W   = 16;
    localparam int DATA_W = 8;
    localparam int SP_W   = 8;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_JSR  = 2'd1,
        OP_RTS  = 2'd2,
        OP_RTI  = 2'd3
    } op_kind_e;

    // Declaration order is the step order within each sequence.
    typedef enum logic [4:0] {
        S_IDLE,
        S_N0, S_N1, S_N2, S_N3, S_N4, S_N5, S_N6,
        S_J0, S_J1, S_J2, S_J3, S_J4, S_J5,
        S_R0, S_R1, S_R2, S_R3, S_R4, S_R5,
        S_I0, S_I1, S_I2, S_I3, S_I4, S_I5
    } seq_state_e;

    typedef enum logic [1:0] {
        SP_HOLD,
        SP_DEC,
        SP_INC
    } sp_op_e;

    typedef struct packed {
        logic [PC_W-1:0]   addr;
        logic [DATA_W-1:0] wdata;
        logic              we;
        sp_op_e            sp_op;
    } bus_cmd_t;

    function automatic logic [PC_W-1:0] stack_addr(input logic [7:0] page,
                                                   input logic [SP_W-1:0] ptr);
        return {page, ptr};
    endfunction

endpackage

// File: rtl/nmi_edge_latch.sv
module nmi_edge_latch (
    input  logic clk,
    input  logic rst,
    input  logic nmi_n,
    input  logic take,
    output logic pending
);
    logic nmi_q;
    logic fall;

    assign fall = nmi_q & ~nmi_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q   <= 1'b1;
            pending <= 1'b0;
        end else begin
            nmi_q <= nmi_n;
            if (fall)
                pending <= 1'b1;
            else if (take)
                pending <= 1'b0;
        end
    end
endmodule

// File: rtl/nmi_stack_ptr.sv
module nmi_stack_ptr
    import nmi_seq_pkg::*;
#(
    parameter logic [SP_W-1:0] SP_RESET = 8'hFF
) (
    input  logic            clk,
    input  logic            rst,
    input  sp_op_e          sp_op,
    output logic [SP_W-1:0] sp,
    output logic [SP_W-1:0] sp_up
);
    assign sp_up = sp + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= SP_RESET;
        end else begin
            unique case (sp_op)
                SP_DEC:  sp <= sp - 1'b1;
                SP_INC:  sp <= sp_up;
                default: sp <= sp;
            endcase
        end
    end
endmodule

// File: rtl/nmi_seq_core.sv
module nmi_seq_core
    import nmi_seq_pkg::*;
#(
    parameter logic [7:0]      STACK_PAGE = 8'h01,
    parameter logic [PC_W-1:0] VEC_LO     = 16'hFFFA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_done,
    input  op_kind_e          op_kind,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DATA_W-1:0] flags_in,
    input  logic [DATA_W-1:0] rdata,
    input  logic              pending,
    input  logic [SP_W-1:0]   sp,
    input  logic [SP_W-1:0]   sp_up,
    output bus_cmd_t          cmd,
    output logic              take,
    output logic              busy,
    output logic [PC_W-1:0]   pc_out,
    output logic              pc_valid,
    output logic [DATA_W-1:0] flags_out
);
    localparam logic [PC_W-1:0] VEC_HI = VEC_LO + 1'b1;

    seq_state_e        state, nxt;
    logic [PC_W-1:0]   cur_pc;
    logic [PC_W-1:0]   new_pc;
    logic [PC_W-1:0]   ret_addr;
    logic [DATA_W-1:0] tmp;
    logic              last;
    logic              idle_bnd;

    assign busy     = (state != S_IDLE);
    assign idle_bnd = (state == S_IDLE) && instr_done;
    assign take     = pending && (idle_bnd || last);
    assign ret_addr = cur_pc + 16'd2;

    // Bus command and end-of-sequence decode
    always_comb begin
        cmd.addr  = cur_pc;
        cmd.wdata = '0;
        cmd.we    = 1'b0;
        cmd.sp_op = SP_HOLD;
        last      = 1'b0;
        new_pc    = cur_pc;
        unique case (state)
            S_N2: begin
                cmd.addr = stack_addr(STACK_PAGE, sp); cmd.we = 1'b1;
                cmd.wdata = cur_pc[15:8]; cmd.sp_op = SP_DEC;
            end
            S_N3: begin
                cmd.addr = stack_addr(STACK_PAGE, sp); cmd.we = 1'b1;
                cmd.wdata = cur_pc[7:0]; cmd.sp_op = SP_DEC;
            end
            S_N4: begin
                cmd.addr = stack_addr(STACK_PAGE, sp); cmd.we = 1'b1;
                cmd.wdata = flags_in; cmd.sp_op = SP_DEC;
            end
            S_N5: cmd.addr = VEC_LO;
            S_N6: begin
                cmd.addr = VEC_HI;
                last     = 1'b1;
                new_pc   = {rdata, tmp};
            end
            S_J1: cmd.addr = cur_pc + 16'd1;
            S_J2, S_R1, S_I1: cmd.addr = stack_addr(STACK_PAGE, sp);
            S_J3: begin
                cmd.addr = stack_addr(STACK_PAGE, sp); cmd.we = 1'b1;
                cmd.wdata = ret_addr[15:8]; cmd.sp_op = SP_DEC;
            end
            S_J4: begin
                cmd.addr = stack_addr(STACK_PAGE, sp); cmd.we = 1'b1;
                cmd.wdata = ret_addr[7:0]; cmd.sp_op = SP_DEC;
            end
            S_J5: begin
                cmd.addr = ret_addr;
                last     = 1'b1;
                new_pc   = {rdata, tmp};
            end
            S_R2, S_R3, S_I2, S_I3, S_I4: begin
                cmd.addr  = stack_addr(STACK_PAGE, sp_up);
                cmd.sp_op = SP_INC;
            end
            S_R5: begin
                last   = 1'b1;
                new_pc = cur_pc + 16'd1;
            end
            S_I5: last = 1'b1;
            default: ;
        endcase
    end

    // Next state
    always_comb begin
        nxt = state;
        if (state == S_IDLE) begin
            if (instr_done) begin
                if (pending) begin
                    nxt = S_N0;
                end else begin
                    unique case (op_kind)
                        OP_JSR:  nxt = S_J0;
                        OP_RTS:  nxt = S_R0;
                        OP_RTI:  nxt = S_I0;
                        default: nxt = S_IDLE;
                    endcase
                end
            end
        end else if (last) begin
            nxt = pending ? S_N0 : S_IDLE;
        end else begin
            nxt = seq_state_e'(state + 5'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            cur_pc    <= '0;
            tmp       <= '0;
            pc_out    <= '0;
            pc_valid  <= 1'b0;
            flags_out <= '0;
        end else begin
            state    <= nxt;
            pc_valid <= 1'b0;
            if (idle_bnd)
                cur_pc <= pc_in;
            unique case (state)
                S_N5, S_J1, S_R2, S_I3: tmp <= rdata;
                S_R3, S_I4:             cur_pc <= {rdata, tmp};
                S_I2:                   flags_out <= rdata;
                default: ;
            endcase
            if (last) begin
                pc_out   <= new_pc;
                cur_pc   <= new_pc;
                pc_valid <= !pending;
            end
        end
    end
endmodule

// File: rtl/nmi_stack_seq.sv
module nmi_stack_seq
    import nmi_seq_pkg::*;
#(
    parameter logic [SP_W-1:0] SP_RESET   = 8'hFF,
    parameter logic [7:0]      STACK_PAGE = 8'h01,
    parameter logic [PC_W-1:0] VEC_LO     = 16'hFFFA
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_n,
    input  logic              instr_done,
    input  logic [1:0]        op_kind,
    input  logic [PC_W-1:0]   pc_in,
    input  logic [DATA_W-1:0] flags_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [PC_W-1:0]   mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [PC_W-1:0]   pc_out,
    output logic              pc_valid,
    output logic              busy,
    output logic [DATA_W-1:0] flags_out,
    output logic [SP_W-1:0]   sp_out
);
    logic            pending;
    logic            take;
    bus_cmd_t        cmd;
    logic [SP_W-1:0] sp_up;

    nmi_edge_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .nmi_n   (nmi_n),
        .take    (take),
        .pending (pending)
    );

    nmi_stack_ptr #(.SP_RESET(SP_RESET)) u_sp (
        .clk   (clk),
        .rst   (rst),
        .sp_op (cmd.sp_op),
        .sp    (sp_out),
        .sp_up (sp_up)
    );

    nmi_seq_core #(.STACK_PAGE(STACK_PAGE), .VEC_LO(VEC_LO)) u_core (
        .clk        (clk),
        .rst        (rst),
        .instr_done (instr_done),
        .op_kind    (op_kind_e'(op_kind)),
        .pc_in      (pc_in),
        .flags_in   (flags_in),
        .rdata      (mem_rdata),
        .pending    (pending),
        .sp         (sp_out),
        .sp_up      (sp_up),
        .cmd        (cmd),
        .take       (take),
        .busy       (busy),
        .pc_out     (pc_out),
        .pc_valid   (pc_valid),
        .flags_out  (flags_out)
    );

    assign mem_addr  = cmd.addr;
    assign mem_wdata = cmd.wdata;
    assign mem_we    = cmd.we;
endmodule

// File: rtl/nmi_stack_seq_chk.sv
module nmi_stack_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        instr_done,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic        pc_valid,
    input logic        busy,
    input logic [7:0]  sp_out
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!busy && !pc_valid && sp_out == 8'hFF));

    assert_start_at_boundary_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !instr_done) |=> !busy);

    assert_push_moves_sp_R3: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (sp_out == $past(sp_out) - 8'd1));

    assert_write_in_stack_R10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (busy && mem_addr[15:8] == 8'h01));

    assert_valid_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
        pc_valid |-> (!busy && $past(busy)));

    assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
        pc_valid |=> !pc_valid);
endmodule

bind nmi_stack_seq nmi_stack_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .instr_done (instr_done),
    .mem_addr   (mem_addr),
    .mem_we     (mem_we),
    .pc_valid   (pc_valid),
    .busy       (busy),
    .sp_out     (sp_out)
);

// File: tb/sim_nmi_stack_seq.sv
`timescale 1ns/1ps
module sim_nmi_stack_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        nmi_n = 1'b1;
    logic        instr_done = 1'b0;
    logic [1:0]  op_kind = 2'd0;
    logic [15:0] pc_in = 16'h0;
    logic [7:0]  flags_in = 8'h0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [15:0] pc_out;
    logic        pc_valid;
    logic        busy;
    logic [7:0]  flags_out;
    logic [7:0]  sp_out;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    logic [7:0] stk [256];
    logic [7:0] vec_lo = 8'h00;
    logic [7:0] vec_hi = 8'h90;
    logic [7:0] exp_sp;

    always #4 clk = ~clk;

    nmi_stack_seq u0 (
        .clk(clk), .rst(rst), .nmi_n(nmi_n), .instr_done(instr_done),
        .op_kind(op_kind), .pc_in(pc_in), .flags_in(flags_in),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .pc_out(pc_out), .pc_valid(pc_valid), .busy(busy),
        .flags_out(flags_out), .sp_out(sp_out)
    );

    function automatic logic [7:0] code_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    always_comb begin
        if (mem_addr[15:8] == 8'h01)  mem_rdata = stk[mem_addr[7:0]];
        else if (mem_addr == 16'hFFFA) mem_rdata = vec_lo;
        else if (mem_addr == 16'hFFFB) mem_rdata = vec_hi;
        else                           mem_rdata = code_byte(mem_addr);
    end

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++)
                stk[i] <= (i == 0) ? 8'h34 : (i == 1) ? 8'h12 : (8'(i) ^ 8'hA5);
        end else if (mem_we && mem_addr[15:8] == 8'h01) begin
            stk[mem_addr[7:0]] <= mem_wdata;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    // R10: writes only to the stack page
    always @(negedge clk) begin
        if (!rst && mem_we && mem_addr[15:8] != 8'h01) begin
            checks++; errs++;
            $display("FAIL R10 write address: actual %0h expected 01xx", mem_addr);
        end
    end

    task automatic bnd(input logic [1:0] k, input logic [15:0] pc, input logic [7:0] fl);
        @(negedge clk);
        instr_done = 1'b1; op_kind = k; pc_in = pc; flags_in = fl;
        @(negedge clk);
        instr_done = 1'b0; op_kind = 2'd0;
    endtask

    task automatic settle(output int n, output int pv);
        n = 0; pv = 0;
        while (busy && n < 100) begin
            n++;
            if (pc_valid) pv++;
            @(negedge clk);
        end
    endtask

    task automatic pulse_check(input string req);
        chk(req, "pc_valid at end", 32'(pc_valid), 32'd1);
        @(negedge clk);
        chk(req, "pc_valid one cycle", 32'(pc_valid), 32'd0);
    endtask

    task automatic do_entry(input logic [1:0] k, input logic [15:0] pc,
                            input logic [7:0] fl, input bit hold, input string req);
        int n, pv;
        logic [7:0] s;
        s = exp_sp;
        vec_lo = 8'($urandom); vec_hi = 8'($urandom) | 8'h80;
        @(negedge clk); nmi_n = 1'b0;
        @(negedge clk); if (!hold) nmi_n = 1'b1;
        @(negedge clk);
        chk("R2", "no entry without boundary", 32'(busy), 32'd0);
        bnd(k, pc, fl);
        settle(n, pv);
        chk(req, "entry cycles", 32'(n), 32'd7);
        chk("R3", "pushed pc hi", 32'(stk[s]), 32'(pc[15:8]));
        chk("R3", "pushed pc lo", 32'(stk[8'(s - 8'd1)]), 32'(pc[7:0]));
        chk("R3", "pushed flags", 32'(stk[8'(s - 8'd2)]), 32'(fl));
        chk("R3", "sp after entry", 32'(sp_out), 32'(8'(s - 8'd3)));
        chk("R3", "handler pc", 32'(pc_out), 32'({vec_hi, vec_lo}));
        exp_sp = s - 8'd3;
        pulse_check("R8");
    endtask

    task automatic do_jsr(input logic [15:0] pc);
        int n, pv;
        logic [7:0] s;
        logic [15:0] ret;
        s = exp_sp; ret = pc + 16'd2;
        bnd(2'd1, pc, 8'h00);
        settle(n, pv);
        chk("R5", "jsr cycles", 32'(n), 32'd6);
        chk("R5", "jsr target", 32'(pc_out), 32'({code_byte(pc + 16'd2), code_byte(pc + 16'd1)}));
        chk("R5", "jsr pushed hi", 32'(stk[s]), 32'(ret[15:8]));
        chk("R5", "jsr pushed lo", 32'(stk[8'(s - 8'd1)]), 32'(ret[7:0]));
        chk("R5", "jsr sp", 32'(sp_out), 32'(8'(s - 8'd2)));
        exp_sp = s - 8'd2;
        pulse_check("R8");
    endtask

    task automatic do_rts(input string req, output logic [15:0] got);
        int n, pv;
        logic [7:0] s;
        logic [15:0] e;
        s = exp_sp;
        e = {stk[8'(s + 8'd2)], stk[8'(s + 8'd1)]} + 16'd1;
        bnd(2'd2, 16'h0300, 8'h00);
        settle(n, pv);
        chk("R6", "rts cycles", 32'(n), 32'd6);
        chk("R6", "rts pc", 32'(pc_out), 32'(e));
        chk(req, "rts sp", 32'(sp_out), 32'(8'(s + 8'd2)));
        exp_sp = s + 8'd2;
        got = pc_out;
        pulse_check("R8");
    endtask

    task automatic do_rti(input logic [15:0] exp_pc, input logic [7:0] exp_fl);
        int n, pv;
        logic [7:0] s;
        s = exp_sp;
        bnd(2'd3, 16'h0400, 8'h00);
        settle(n, pv);
        chk("R7", "rti cycles", 32'(n), 32'd6);
        chk("R7", "rti pc unchanged", 32'(pc_out), 32'(exp_pc));
        chk("R7", "rti flags", 32'(flags_out), 32'(exp_fl));
        chk("R7", "rti sp", 32'(sp_out), 32'(8'(s + 8'd3)));
        exp_sp = s + 8'd3;
        pulse_check("R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errs++;
            $display("FAIL R8 watchdog: actual busy=%0d expected run to finish", busy);
            $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        void'($urandom(32'd20240611));
        exp_sp = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "busy", 32'(busy), 32'd0);
        chk("R1", "pc_valid", 32'(pc_valid), 32'd0);
        chk("R1", "mem_we", 32'(mem_we), 32'd0);
        chk("R1", "sp", 32'(sp_out), 32'hFF);
        chk("R1", "flags_out", 32'(flags_out), 32'd0);
        chk("R1", "pc_out", 32'(pc_out), 32'd0);

        // R12: pull from SP=FF wraps to 00 and 01
        do_rts("R12", r);
        chk("R12", "wrapped return", 32'(r), 32'h1235);

        // R12 and R3: entry pushes across 01 -> 00 -> FF
        do_entry(2'd0, 16'h2345, 8'hC3, 1'b0, "R3");
        do_rti(16'h2345, 8'hC3);

        // R2: level held low does not re-trigger
        do_entry(2'd0, 16'h0ABC, 8'h11, 1'b1, "R2");
        bnd(2'd0, 16'h0AC0, 8'h00);
        chk("R2", "held low no retrigger", 32'(busy), 32'd0);
        nmi_n = 1'b1;
        bnd(2'd0, 16'h0AC1, 8'h00);
        chk("R2", "rising edge no trigger", 32'(busy), 32'd0);
        do_rti(16'h0ABC, 8'h11);

        // R4: pending interrupt beats a JSR request
        do_entry(2'd1, 16'h1F00, 8'h5E, 1'b0, "R4");
        do_rti(16'h1F00, 8'h5E);

        // R9: instr_done while busy ignored
        begin
            int n, pv;
            logic [7:0] s;
            s = exp_sp;
            bnd(2'd1, 16'h0600, 8'h00);
            instr_done = 1'b1; op_kind = 2'd3;
            @(negedge clk);
            instr_done = 1'b0; op_kind = 2'd0;
            settle(n, pv);
            chk("R9", "jsr cycles with stray done", 32'(n + 1), 32'd6);
            chk("R9", "sp unaffected", 32'(sp_out), 32'(8'(s - 8'd2)));
            chk("R9", "target unaffected", 32'(pc_out), 32'({code_byte(16'h0602), code_byte(16'h0601)}));
            exp_sp = s - 8'd2;
            pulse_check("R8");
        end

        // R11: edge during RTS chains into entry
        begin
            int n, pv;
            logic [7:0] s;
            logic [15:0] e;
            s = exp_sp;
            e = {stk[8'(s + 8'd2)], stk[8'(s + 8'd1)]} + 16'd1;
            vec_lo = 8'h40; vec_hi = 8'hC1;
            bnd(2'd2, 16'h0700, 8'h77);
            @(negedge clk); nmi_n = 1'b0;
            @(negedge clk); nmi_n = 1'b1;
            settle(n, pv);
            chk("R11", "chained cycles", 32'(n + 2), 32'd13);
            chk("R8", "no pulse between chained", 32'(pv), 32'd0);
            chk("R11", "pushed hi", 32'(stk[8'(s + 8'd2)]), 32'(e[15:8]));
            chk("R11", "pushed lo", 32'(stk[8'(s + 8'd1)]), 32'(e[7:0]));
            chk("R11", "pushed flags", 32'(stk[s]), 32'h77);
            chk("R11", "sp", 32'(sp_out), 32'(8'(s - 8'd1)));
            chk("R11", "handler pc", 32'(pc_out), 32'h C140);
            exp_sp = s - 8'd1;
            pulse_check("R8");
            do_rti(e, 8'h77);
        end

        // Random mix of call/return and interrupt/return pairs
        for (int it = 0; it < 30; it++) begin
            logic [15:0] pc;
            logic [7:0]  fl;
            pc = 16'h0200 + 16'($urandom % 16'h7000);
            fl = 8'($urandom);
            if ($urandom % 2 == 0) begin
                do_jsr(pc);
                do_rts("R6", r);
                chk("R6", "rts returns past jsr", 32'(r), 32'(pc + 16'd3));
            end else begin
                do_entry(2'($urandom), pc, fl, 1'b0, "R3");
                do_rti(pc, fl);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
        $finish;
    end
endmodule